// File: doc/BRIEF.md
# Up/Down Interval Timer with Shadowed Period and Compare

This block is the counting core of a general-purpose timer. A free-running system clock drives all registers, and a one-cycle `tick` input says when the counter may move one step. A direction input picks counting up or counting down. The counter runs between zero and a programmable period. Counting up, it returns to zero after it reaches the period. Counting down, it is reloaded from the period after it reaches zero. Either event is the wrap point of the block and raises a one-cycle wrap pulse.

The period and a single compare value each have an active register and a shadow buffer with a valid flag. When software writes a shadow, its valid flag is set. The shadow moves into the active register only at the next wrap point, so a new period or compare value always starts on a clean cycle boundary. Software may also write an active register directly. This bypasses the shadow, which is useful for initialisation. A compare-match pulse marks each tick on which the counter equals the active compare value.

Top module: `updn_timer_core`

## Requirements
- R1: On a cycle with `tick` high the counter moves by exactly one step: up when `dir_down` is 0 and down when it is 1. On a cycle with `tick` low it keeps its value.
- R2: Counting up, a tick taken while the count equals the active period sets the count to zero. `wrap_pulse` is high for the one clock cycle that follows that tick.
- R3: Counting down, a tick taken at count zero loads the period value that is in force after that cycle's update: the shadow if its flag is valid, or else the active period. `wrap_pulse` is high for the following cycle.
- R4: A write with `wr_sel`=1 stores `wr_data` in the period shadow, and a write with `wr_sel`=3 stores it in the compare shadow. Either write sets that shadow's valid flag and leaves the active value unchanged.
- R5: At a wrap point each shadow whose flag is valid is copied into its active register, and its flag is cleared. A shadow whose flag is not valid leaves its active register as it was. A shadow write in the same cycle keeps the flag set.
- R6: A write with `wr_sel`=0 sets the active period, and a write with `wr_sel`=2 sets the active compare, on the next cycle. The valid flags are not changed. If a commit falls in the same cycle, the direct write sets the active value and the commit still clears the flag.
- R7: `match_pulse` is high for the one clock cycle after each tick on which the count, before the step, equals the active compare value. It is low at all other times.
- R8: A synchronous reset clears the count, the active compare, both shadows, both valid flags and both pulses, and sets the active period to all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one step per high cycle |
| dir_down | input | 1 | 0 counts up, 1 counts down |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 period active, 1 period shadow, 2 compare active, 3 compare shadow |
| wr_data | input | CNT_W | Write data |
| count | output | CNT_W | Current count |
| period | output | CNT_W | Active period |
| compare | output | CNT_W | Active compare value |
| per_pending | output | 1 | Period shadow valid flag |
| cmp_pending | output | 1 | Compare shadow valid flag |
| match_pulse | output | 1 | Compare-match pulse |
| wrap_pulse | output | 1 | Overflow/underflow pulse |

## Verification
The count, both active registers and both valid flags are visible at the ports, so a wrong internal state shows up on the clock edge after the faulty step. A lost commit or a valid flag that stays set shows at the first wrap point after a shadow write. A reload that uses the stale period shows as a wrong count one cycle after the tick that underflows. The reference model compares every output on every cycle, across tick gaps, direction changes, a period of zero, and direct writes that land in the same cycle as a commit.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;
  typedef enum logic [1:0] {
    SEL_PER_ACT = 2'd0,
    SEL_PER_BUF = 2'd1,
    SEL_CMP_ACT = 2'd2,
    SEL_CMP_BUF = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/tmr_shadow_reg.sv
module tmr_shadow_reg #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_ACT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         upd,
  input  logic         wr_act,
  input  logic         wr_buf,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] act_q,
  output logic [W-1:0] buf_q,
  output logic         valid_q,
  output logic [W-1:0] commit_val
);
  // value that is in force after a commit in this cycle
  assign commit_val = valid_q ? buf_q : act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= RST_ACT;
      buf_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (wr_act)              act_q <= wdata;
      else if (upd && valid_q) act_q <= buf_q;
      if (wr_buf) begin
        buf_q   <= wdata;
        valid_q <= 1'b1;
      end else if (upd) begin
        valid_q <= 1'b0;
      end
    end
  end

  // R5: a valid shadow reaches the active register at the update
  assert_commit_R5: assert property (@(posedge clk) disable iff (rst)
    (upd && valid_q && !wr_act) |=> (act_q == $past(buf_q)));
  // R5: the update consumes the flag unless the shadow is rewritten
  assert_flag_clear_R5: assert property (@(posedge clk) disable iff (rst)
    (upd && !wr_buf) |=> !valid_q);
  // R4: a shadow write marks it valid
  assert_flag_set_R4: assert property (@(posedge clk) disable iff (rst)
    wr_buf |=> valid_q);
  // R6: a direct write leaves the flag alone
  assert_direct_keeps_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_act && !wr_buf && !upd) |=> (valid_q == $past(valid_q)));
  // R6: a direct write wins over the commit
  assert_direct_value_R6: assert property (@(posedge clk) disable iff (rst)
    wr_act |=> (act_q == $past(wdata)));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         dir_down,
  input  logic [W-1:0] period,
  input  logic [W-1:0] reload_val,
  input  logic [W-1:0] compare,
  output logic [W-1:0] cnt_q,
  output logic         wrap_evt,
  output logic         match_q,
  output logic         wrap_q
);
  localparam logic [W-1:0] STEP   = W'(1);
  localparam logic [W-1:0] BOTTOM = '0;

  logic at_end;
  logic [W-1:0] cnt_next;

  always_comb begin
    at_end   = dir_down ? (cnt_q == BOTTOM) : (cnt_q == period);
    wrap_evt = tick && at_end;
    cnt_next = cnt_q;
    if (tick) begin
      if (dir_down) cnt_next = at_end ? reload_val : cnt_q - STEP;
      else          cnt_next = at_end ? BOTTOM     : cnt_q + STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      match_q <= 1'b0;
      wrap_q  <= 1'b0;
    end else begin
      cnt_q   <= cnt_next;
      match_q <= tick && (cnt_q == compare);
      wrap_q  <= wrap_evt;
    end
  end

  // R1: no tick, no movement
  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt_q));
  // R1: single up step away from the end
  assert_up_step_R1: assert property (@(posedge clk) disable iff (rst)
    (tick && !dir_down && cnt_q != period) |=> (cnt_q == $past(cnt_q) + STEP));
  // R2: up wrap to zero
  assert_up_wrap_R2: assert property (@(posedge clk) disable iff (rst)
    (tick && !dir_down && cnt_q == period) |=> (cnt_q == BOTTOM && wrap_q));
  // R3: down reload
  assert_down_reload_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && dir_down && cnt_q == BOTTOM) |=> (cnt_q == $past(reload_val) && wrap_q));
  // R7: a match pulse only follows a tick
  assert_match_after_tick_R7: assert property (@(posedge clk) disable iff (rst)
    match_q |-> $past(tick));
endmodule

// File: rtl/updn_timer_core.sv
module updn_timer_core
  import updn_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             dir_down,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] compare,
  output logic             per_pending,
  output logic             cmp_pending,
  output logic             match_pulse,
  output logic             wrap_pulse
);
  localparam logic [CNT_W-1:0] PER_RST = '1;
  localparam logic [CNT_W-1:0] CMP_RST = '0;

  wr_sel_e sel;
  logic upd;
  logic [CNT_W-1:0] per_commit, cmp_commit, per_buf, cmp_buf;

  assign sel = wr_sel_e'(wr_sel);

  tmr_shadow_reg #(.W(CNT_W), .RST_ACT(PER_RST)) u_per (
    .clk(clk), .rst(rst), .upd(upd),
    .wr_act(wr_en && sel == SEL_PER_ACT),
    .wr_buf(wr_en && sel == SEL_PER_BUF),
    .wdata(wr_data), .act_q(period), .buf_q(per_buf),
    .valid_q(per_pending), .commit_val(per_commit));

  tmr_shadow_reg #(.W(CNT_W), .RST_ACT(CMP_RST)) u_cmp (
    .clk(clk), .rst(rst), .upd(upd),
    .wr_act(wr_en && sel == SEL_CMP_ACT),
    .wr_buf(wr_en && sel == SEL_CMP_BUF),
    .wdata(wr_data), .act_q(compare), .buf_q(cmp_buf),
    .valid_q(cmp_pending), .commit_val(cmp_commit));

  tmr_count_core #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .dir_down(dir_down),
    .period(period), .reload_val(per_commit), .compare(compare),
    .cnt_q(count), .wrap_evt(upd), .match_q(match_pulse), .wrap_q(wrap_pulse));

  // R4: shadow write does not touch the active period
  assert_buf_isolated_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_PER_BUF && !upd) |=> $stable(period));
  // R8: reset state
  assert_reset_state_R8: assert property (@(posedge clk)
    rst |=> (count == '0 && period == PER_RST && !per_pending && !cmp_pending));
endmodule

// File: tb/updn_timer_core_tb_top.sv
module updn_timer_core_tb_top;
  localparam int W = 16;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, dir_down = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] count, period, compare;
  logic per_pending, cmp_pending, match_pulse, wrap_pulse;

  int total = 0, bad = 0;
  string phase = "R8";

  // reference state
  logic [W-1:0] m_cnt, m_per, m_cmp, m_pbuf, m_cbuf;
  logic m_pv, m_cv, m_match, m_wrap;

  always #5 clk = ~clk;

  updn_timer_core #(.CNT_W(W)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .dir_down(dir_down), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .count(count), .period(period),
    .compare(compare), .per_pending(per_pending), .cmp_pending(cmp_pending),
    .match_pulse(match_pulse), .wrap_pulse(wrap_pulse));

  task automatic chk(string what, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: got %0d expected %0d at %0t", phase, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_cnt = '0; m_per = '1; m_cmp = '0; m_pbuf = '0; m_cbuf = '0;
    m_pv = 0; m_cv = 0; m_match = 0; m_wrap = 0;
  endtask

  task automatic model_step();
    logic wrap;
    logic [W-1:0] reload;
    wrap    = tick && (dir_down ? (m_cnt == 0) : (m_cnt == m_per));
    m_match = tick && (m_cnt == m_cmp);
    m_wrap  = wrap;
    reload  = m_pv ? m_pbuf : m_per;
    if (tick) begin
      if (dir_down) m_cnt = wrap ? reload : m_cnt - 1'b1;
      else          m_cnt = wrap ? '0 : m_cnt + 1'b1;
    end
    if (wrap && m_pv) begin m_per = m_pbuf; m_pv = 0; end
    if (wrap && m_cv) begin m_cmp = m_cbuf; m_cv = 0; end
    if (wr_en) begin
      case (wr_sel)
        2'd0: m_per = wr_data;
        2'd1: begin m_pbuf = wr_data; m_pv = 1; end
        2'd2: m_cmp = wr_data;
        default: begin m_cbuf = wr_data; m_cv = 1; end
      endcase
    end
  endtask

  task automatic compare_all();
    chk("count R1", count, m_cnt);
    chk("period R5", period, m_per);
    chk("compare R5", compare, m_cmp);
    chk("per_pending R4", W'(per_pending), W'(m_pv));
    chk("cmp_pending R4", W'(cmp_pending), W'(m_cv));
    chk("match_pulse R7", W'(match_pulse), W'(m_match));
    chk("wrap_pulse R2", W'(wrap_pulse), W'(m_wrap));
  endtask

  // one clock with the given inputs, then model and compare
  task automatic cyc(input logic t, input logic d, input logic we,
                     input logic [1:0] s, input logic [W-1:0] dat);
    tick = t; dir_down = d; wr_en = we; wr_sel = s; wr_data = dat;
    @(posedge clk); #1;
    model_step();
    compare_all();
    #3;
  endtask

  initial begin
    #(20000 * 10);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    #1; compare_all();                 // R8 reset values
    #3; rst = 1'b0;
    cyc(0, 0, 0, 0, 0);

    phase = "R6";                      // direct writes
    cyc(0, 0, 1, 2'd0, 16'd4);
    cyc(0, 0, 1, 2'd2, 16'd2);
    cyc(0, 0, 0, 0, 0);

    phase = "R2";                      // up counting with wrap
    for (int i = 0; i < 12; i++) cyc(1, 0, 0, 0, 0);
    phase = "R1";                      // sparse ticks
    for (int i = 0; i < 14; i++) cyc(i % 3 == 0, 0, 0, 0, 0);

    phase = "R4";                      // shadow writes held back
    cyc(0, 0, 1, 2'd1, 16'd6);
    cyc(0, 0, 1, 2'd3, 16'd5);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0);
    phase = "R5";
    for (int i = 0; i < 20; i++) cyc(1, 0, 0, 0, 0);

    phase = "R3";                      // down counting, reload uses new shadow
    cyc(0, 1, 1, 2'd1, 16'd2);
    for (int i = 0; i < 24; i++) cyc(1, 1, 0, 0, 0);

    phase = "R6";                      // direct write on the commit cycle
    cyc(0, 1, 1, 2'd1, 16'd3);
    cyc(0, 1, 1, 2'd3, 16'd1);
    for (int i = 0; i < 12; i++) begin
      if (m_cnt == 0 && m_pv) cyc(1, 1, 1, 2'd0, 16'd7);
      else                    cyc(1, 1, 0, 0, 0);
    end
    for (int i = 0; i < 10; i++) cyc(1, 1, 0, 0, 0);

    phase = "R7";                      // period zero, compare zero
    cyc(0, 0, 1, 2'd0, 16'd0);
    cyc(0, 0, 1, 2'd2, 16'd0);
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 0);
    cyc(1, 0, 1, 2'd3, 16'd1);
    for (int i = 0; i < 6; i++) cyc(i % 2 == 0, 0, 0, 0, 0);

    phase = "R8";
    rst = 1'b1;
    @(posedge clk); #1;
    model_reset();
    compare_all();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule